// File: doc/BRIEF.md
# Transmit DMA Status and Descriptor-Base Registers

This block is the register slice that sits beside a transmit/receive DMA engine. It holds two things. The first is the start address of the transmit descriptor ring, which the DMA reads whenever transmission starts. The second is the DMA status word, which gathers the event flags raised by the two DMA engines, a captured bus-error source, the live transmit process state, and copies of three sub-block interrupt levels. An interrupt-enable register picks which status flags may drive the single interrupt line, and that line is registered.

Software reaches the three registers through a simple select/write/read port. A register select code picks the target: 0 is the descriptor base, 1 is the status word, 2 is the interrupt enable and 3 is unused. Reads are combinational and have no side effects. Status flags are cleared by writing ones. The descriptor base can only be changed while the transmit DMA is stopped. Its low address bits are forced to zero according to the configured bus width.

Top module: `txdma_status_regs`

## Requirements
- R1: After reset the descriptor base, status flags, error code and interrupt enables read 0 and `irq` is 0.
- R2: A write with `reg_sel`=0 updates the descriptor base only when `tx_run` is 0. With `tx_run`=1 the write is ignored.
- R3: The low bits of the descriptor base are forced to zero, both when stored and on `desc_base`/readback. `bus_width` 0 (32-bit) clears bits 1:0, 1 (64-bit) clears bits 2:0, and 2 or 3 (128-bit) clear bits 3:0.
- R4: Status bits 16:0 are write-1-to-clear through `reg_sel`=1. Writing a 0 bit, or any read, leaves a bit unchanged.
- R5: An `evt_set` pulse on bit i sets status bit i on the next clock. When an event and a write-1-clear hit the same bit in one cycle, the bit stays set.
- R6: `irq` goes to 1 one clock after any status bit in 16:0 is pending with its enable bit (`reg_sel`=2, bit i enables status bit i) set. It goes to 0 one clock after no such bit remains.
- R7: A `bus_err` pulse sets status bit 13 and captures `bus_err_src` into status bits 25:23. The code holds until the next `bus_err`, including after bit 13 is cleared, and it raises the interrupt only through bit 13's enable.
- R8: Status bits 29, 28 and 27 show `ts_irq`, `pm_irq` and `cnt_irq` as live levels, and status writes do not change them.
- R9: Status bits 22:20 show `tx_state`. Bits 31:30, 26 and 19:17 read 0.
- R10: `reg_sel`=3 reads 0, and a write to it changes no register.
- R11: When `tx_run` falls and rises again with no base write in between, `desc_base` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select (0 base, 1 status, 2 enable, 3 none) |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Combinational read data of the selected register |
| tx_run | input | 1 | Transmit DMA running (start bit) |
| bus_width | input | 2 | Bus width code: 0 32-bit, 1 64-bit, 2/3 128-bit |
| evt_set | input | 17 | One-cycle event pulses setting status bits 16:0 |
| bus_err | input | 1 | Fatal bus error pulse |
| bus_err_src | input | 3 | Source code of the bus error |
| tx_state | input | 3 | Transmit process state |
| ts_irq | input | 1 | Timestamp sub-block interrupt level |
| pm_irq | input | 1 | Power-management sub-block interrupt level |
| cnt_irq | input | 1 | Counter sub-block interrupt level |
| desc_base | output | 32 | Descriptor ring base for the DMA, low bits masked |
| irq | output | 1 | Registered interrupt output |

## Verification
The case that is hardest to reach from the ports is a hardware event and a software clear landing on the same status bit in the same cycle. The bench gets there by driving `evt_set` and a status write with the same bit set on one falling edge, for every flag position. Width-dependent masking of a stored base is also tricky, because the stored value was masked with the width in force when it was written. The bench reaches it by writing at one width and then reading back at every other width.

// File: rtl/txdma_regs_pkg.sv
// Package: shared constants, select codes and helpers for the transmit
// DMA status / descriptor-base register slice.
// Assumes a 32-bit register word; address width is a parameter of users.
package txdma_regs_pkg;

    localparam int STS_W     = 17;  // write-1-to-clear flag bits
    localparam int ERR_W     = 3;   // bus-error source code width
    localparam int STATE_W   = 3;   // transmit process state width
    localparam int BW_W      = 2;   // bus width code width
    localparam int FATAL_BIT = 13;  // flag raised by a bus error
    localparam int ERR_LSB   = 23;  // error code position in status word
    localparam int STATE_LSB = 20;  // tx state position in status word
    localparam int CNT_BIT   = 27;  // counter sub-block mirror
    localparam int PM_BIT    = 28;  // power-management mirror
    localparam int TS_BIT    = 29;  // timestamp mirror

    typedef enum logic [1:0] {
        SEL_BASE = 2'd0,
        SEL_STS  = 2'd1,
        SEL_IEN  = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    // Low address bits that must read zero for a bus width code.
    function automatic logic [3:0] low_clear(input logic [BW_W-1:0] bw);
        case (bw)
            2'd0:    low_clear = 4'b0011;
            2'd1:    low_clear = 4'b0111;
            default: low_clear = 4'b1111;
        endcase
    endfunction

endpackage

// File: rtl/dma_base_reg.sv
// Module: descriptor ring base register.
// Accepts a write only while the transmit DMA is stopped, stores it with
// the low bits cleared for the width in force, and presents it masked
// again with the current width. Assumes ADDR_W >= 4.
module dma_base_reg
    import txdma_regs_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [ADDR_W-1:0] wdata,
    input  logic              tx_run,
    input  logic [BW_W-1:0]   bus_width,
    output logic [ADDR_W-1:0] base
);

    localparam int HI_W = ADDR_W - 4;

    logic [ADDR_W-1:0] keep_mask;
    logic [ADDR_W-1:0] base_q;

    // Purpose: build the keep-mask for the current bus width.
    always_comb begin
        keep_mask = {{HI_W{1'b1}}, ~low_clear(bus_width)};
    end

    // Purpose: hold the base; write only when transmit DMA is stopped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
        end else if (wr && !tx_run) begin
            base_q <= wdata & keep_mask;
        end
    end

    assign base = base_q & keep_mask;

endmodule

// File: rtl/dma_w1c_flags.sv
// Module: bank of write-1-to-clear flags.
// Each bit sets on its event pulse and clears on a clear request; when
// both arrive in one cycle the event wins. Reads have no effect here.
module dma_w1c_flags #(
    parameter int W = 17
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set,
    input  logic [W-1:0] clr,
    output logic [W-1:0] pend
);

    for (genvar i = 0; i < W; i++) begin : g_flag
        // Purpose: one flag, event has priority over software clear.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pend[i] <= 1'b0;
            end else if (set[i]) begin
                pend[i] <= 1'b1;
            end else if (clr[i]) begin
                pend[i] <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/dma_err_capture.sv
// Module: bus-error source capture.
// Latches the source code on each bus-error pulse and keeps it until the
// next one; it has no interrupt path of its own.
module dma_err_capture #(
    parameter int EW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_err,
    input  logic [EW-1:0] src,
    output logic [EW-1:0] code
);

    // Purpose: sticky capture of the last bus-error source.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code <= '0;
        end else if (bus_err) begin
            code <= src;
        end
    end

endmodule

// File: rtl/dma_irq_gen.sv
// Module: masked interrupt generator.
// ORs the enabled pending flags and registers the result for one cycle.
module dma_irq_gen #(
    parameter int W = 17
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pend,
    input  logic [W-1:0] en,
    output logic         irq
);

    logic any_hit;

    // Purpose: detect any enabled pending flag.
    always_comb begin
        any_hit = |(pend & en);
    end

    // Purpose: register the interrupt line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq <= 1'b0;
        end else begin
            irq <= any_hit;
        end
    end

endmodule

// File: rtl/txdma_status_regs.sv
// Module: transmit DMA status and descriptor-base register slice (top).
// Decodes the select/write port, holds the interrupt-enable register,
// assembles the status word from flags, captured error code, tx state and
// sub-block mirrors, and drives the registered interrupt.
// Assumes events and bus errors are single-cycle pulses from the DMA.
module txdma_status_regs
    import txdma_regs_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [1:0]         reg_sel,
    input  logic [31:0]        wr_data,
    output logic [31:0]        rd_data,
    input  logic               tx_run,
    input  logic [BW_W-1:0]    bus_width,
    input  logic [STS_W-1:0]   evt_set,
    input  logic               bus_err,
    input  logic [ERR_W-1:0]   bus_err_src,
    input  logic [STATE_W-1:0] tx_state,
    input  logic               ts_irq,
    input  logic               pm_irq,
    input  logic               cnt_irq,
    output logic [ADDR_W-1:0]  desc_base,
    output logic               irq
);

    logic               wr_base;
    logic               wr_sts;
    logic               wr_ien;
    logic [STS_W-1:0]   flag_set;
    logic [STS_W-1:0]   flag_clr;
    logic [STS_W-1:0]   pend;
    logic [STS_W-1:0]   ien_q;
    logic [ERR_W-1:0]   err_code;
    logic [31:0]        sts_word;

    // Purpose: decode the write strobe per register.
    always_comb begin
        wr_base = wr_en && (reg_sel == SEL_BASE);
        wr_sts  = wr_en && (reg_sel == SEL_STS);
        wr_ien  = wr_en && (reg_sel == SEL_IEN);
    end

    // Purpose: merge event pulses and bus error into flag set/clear.
    always_comb begin
        flag_set            = evt_set;
        flag_set[FATAL_BIT] = evt_set[FATAL_BIT] | bus_err;
        flag_clr            = wr_sts ? wr_data[STS_W-1:0] : '0;
    end

    // Purpose: interrupt-enable register, writable at any time.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ien_q <= '0;
        end else if (wr_ien) begin
            ien_q <= wr_data[STS_W-1:0];
        end
    end

    dma_base_reg #(.ADDR_W(ADDR_W)) u_base (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr        (wr_base),
        .wdata     (wr_data[ADDR_W-1:0]),
        .tx_run    (tx_run),
        .bus_width (bus_width),
        .base      (desc_base)
    );

    dma_w1c_flags #(.W(STS_W)) u_flags (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (flag_set),
        .clr   (flag_clr),
        .pend  (pend)
    );

    dma_err_capture #(.EW(ERR_W)) u_err (
        .clk     (clk),
        .rst_n   (rst_n),
        .bus_err (bus_err),
        .src     (bus_err_src),
        .code    (err_code)
    );

    dma_irq_gen #(.W(STS_W)) u_irq (
        .clk   (clk),
        .rst_n (rst_n),
        .pend  (pend),
        .en    (ien_q),
        .irq   (irq)
    );

    // Purpose: assemble the status word; unlisted bits stay zero.
    always_comb begin
        sts_word                                = '0;
        sts_word[STS_W-1:0]                     = pend;
        sts_word[STATE_LSB +: STATE_W]          = tx_state;
        sts_word[ERR_LSB +: ERR_W]              = err_code;
        sts_word[CNT_BIT]                       = cnt_irq;
        sts_word[PM_BIT]                        = pm_irq;
        sts_word[TS_BIT]                        = ts_irq;
    end

    // Purpose: combinational read mux with no side effects.
    always_comb begin
        rd_data = '0;
        case (reg_sel)
            SEL_BASE: rd_data[ADDR_W-1:0] = desc_base;
            SEL_STS:  rd_data             = sts_word;
            SEL_IEN:  rd_data[STS_W-1:0]  = ien_q;
            default:  rd_data             = '0;
        endcase
    end

endmodule

// File: rtl/txdma_status_regs_chk.sv
// Module: assertion checker for txdma_status_regs, attached by bind.
// Observes ports and the flag, enable and error-code state.
module txdma_status_regs_chk
    import txdma_regs_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic               wr_en,
    input logic [1:0]         reg_sel,
    input logic [31:0]        wr_data,
    input logic [31:0]        rd_data,
    input logic               tx_run,
    input logic [BW_W-1:0]    bus_width,
    input logic [STS_W-1:0]   evt_set,
    input logic               bus_err,
    input logic [ERR_W-1:0]   bus_err_src,
    input logic               ts_irq,
    input logic               pm_irq,
    input logic               cnt_irq,
    input logic [ADDR_W-1:0]  desc_base,
    input logic               irq,
    input logic [STS_W-1:0]   pend,
    input logic [STS_W-1:0]   ien,
    input logic [ERR_W-1:0]   err_code
);

    logic [STS_W-1:0] ev_all;
    logic [STS_W-1:0] clr_only;

    always_comb begin
        ev_all            = evt_set;
        ev_all[FATAL_BIT] = evt_set[FATAL_BIT] | bus_err;
        clr_only          = (wr_en && reg_sel == SEL_STS) ? (wr_data[STS_W-1:0] & ~ev_all) : '0;
    end

    p_base_locked_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_run && wr_en && reg_sel == SEL_BASE && bus_width == $past(bus_width))
        |=> (desc_base == $past(desc_base)) || (bus_width != $past(bus_width)));

    p_low_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (desc_base[3:0] & low_clear(bus_width)) == 4'b0);

    p_w1c_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (|clr_only) |=> ((pend & $past(clr_only)) == '0));

    p_event_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (|ev_all) |=> ((pend & $past(ev_all)) == $past(ev_all)));

    p_irq_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (|(pend & ien)) |=> irq);

    p_irq_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(|(pend & ien)) |=> !irq);

    p_err_capture_r7: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |=> (err_code == $past(bus_err_src)) && pend[FATAL_BIT]);

    p_mirror_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_sel == SEL_STS) |-> (rd_data[TS_BIT:CNT_BIT] == {ts_irq, pm_irq, cnt_irq}));

    p_reserved_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_sel == SEL_STS) |-> (rd_data[31:30] == 2'b0 && !rd_data[26] && rd_data[19:17] == 3'b0));

    p_none_reads_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_sel == SEL_NONE) |-> (rd_data == 32'h0));

endmodule

bind txdma_status_regs txdma_status_regs_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .reg_sel     (reg_sel),
    .wr_data     (wr_data),
    .rd_data     (rd_data),
    .tx_run      (tx_run),
    .bus_width   (bus_width),
    .evt_set     (evt_set),
    .bus_err     (bus_err),
    .bus_err_src (bus_err_src),
    .ts_irq      (ts_irq),
    .pm_irq      (pm_irq),
    .cnt_irq     (cnt_irq),
    .desc_base   (desc_base),
    .irq         (irq),
    .pend        (pend),
    .ien         (ien_q),
    .err_code    (err_code)
);

// File: tb/sim_txdma_status_regs.sv
// Bench: sweeps over flag positions, widths, error codes, mirror levels
// and tx states, with a bench-side register model.
module sim_txdma_status_regs;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  reg_sel = 2'd0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        tx_run = 1'b0;
    logic [1:0]  bus_width = 2'd0;
    logic [16:0] evt_set = '0;
    logic        bus_err = 1'b0;
    logic [2:0]  bus_err_src = '0;
    logic [2:0]  tx_state = '0;
    logic        ts_irq = 1'b0;
    logic        pm_irq = 1'b0;
    logic        cnt_irq = 1'b0;
    logic [31:0] desc_base;
    logic        irq;

    int n_chk = 0;
    int n_fail = 0;

    // bench model
    logic [31:0] m_base;
    logic [16:0] m_pend;
    logic [16:0] m_en;
    logic [2:0]  m_err;

    always #10 clk = ~clk;  // 50 MHz

    txdma_status_regs u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .reg_sel(reg_sel),
        .wr_data(wr_data), .rd_data(rd_data), .tx_run(tx_run),
        .bus_width(bus_width), .evt_set(evt_set), .bus_err(bus_err),
        .bus_err_src(bus_err_src), .tx_state(tx_state), .ts_irq(ts_irq),
        .pm_irq(pm_irq), .cnt_irq(cnt_irq), .desc_base(desc_base), .irq(irq)
    );

    function automatic logic [31:0] keep(input logic [1:0] bw);
        keep = (bw == 2'd0) ? ~32'h3 : (bw == 2'd1) ? ~32'h7 : ~32'hF;
    endfunction

    function automatic logic [31:0] exp_sts();
        exp_sts = {2'b00, ts_irq, pm_irq, cnt_irq, 1'b0, m_err, tx_state, 3'b000, m_pend};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [1:0] sel, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; reg_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic reg_rd(input logic [1:0] sel, output logic [31:0] d);
        reg_sel = sel;
        #1;
        d = rd_data;
    endtask

    task automatic pulse_evt(input logic [16:0] v);
        @(negedge clk);
        evt_set = v;
        @(negedge clk);
        evt_set = '0;
        m_pend = m_pend | v;
    endtask

    task automatic do_w1c(input logic [16:0] v);
        reg_wr(2'd1, {15'h0, v});
        m_pend = m_pend & ~v;
    endtask

    initial begin
        #4000000;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] r;
        logic [31:0] r2;
        m_base = '0; m_pend = '0; m_en = '0; m_err = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        reg_rd(2'd0, r); check("R1 base", r, 32'h0);
        reg_rd(2'd1, r); check("R1 status", r, 32'h0);
        reg_rd(2'd2, r); check("R1 enable", r, 32'h0);
        check("R1 irq", {31'h0, irq}, 32'h0);
        check("R1 desc_base", desc_base, 32'h0);

        // R2, R3: base writes over widths and run states
        for (int bw = 0; bw < 4; bw++) begin
            for (int run = 0; run < 2; run++) begin
                logic [31:0] d;
                d = 32'h1234_5670 ^ (32'h0101_0107 * (bw * 2 + run + 1));
                bus_width = bw[1:0];
                tx_run = run[0];
                reg_wr(2'd0, d);
                if (run == 0) m_base = d & keep(bw[1:0]);
                reg_rd(2'd0, r);
                check("R2 base readback", r, m_base & keep(bw[1:0]));
                check("R3 desc_base low bits", desc_base, m_base & keep(bw[1:0]));
            end
        end
        // R3: write at 32-bit width, view at every width
        tx_run = 1'b0; bus_width = 2'd0;
        reg_wr(2'd0, 32'hFFFF_FFFF);
        m_base = 32'hFFFF_FFFC;
        for (int bw = 0; bw < 4; bw++) begin
            bus_width = bw[1:0];
            #1;
            check("R3 width view", desc_base, m_base & keep(bw[1:0]));
        end
        bus_width = 2'd0;

        // R11: stop/restart without rewrite keeps base
        @(negedge clk); tx_run = 1'b1;
        @(negedge clk); tx_run = 1'b0;
        @(negedge clk); tx_run = 1'b1;
        @(negedge clk);
        check("R11 base kept", desc_base, m_base);
        tx_run = 1'b0;

        // R10: unused select
        reg_wr(2'd3, 32'hA5A5_A5A5);
        reg_rd(2'd3, r); check("R10 none reads 0", r, 32'h0);
        reg_rd(2'd0, r); check("R10 base untouched", r, m_base);
        reg_rd(2'd2, r); check("R10 enable untouched", r, 32'h0);

        // R4: set, read, write 0, write 1 per bit
        for (int i = 0; i < 17; i++) begin
            pulse_evt(17'h1 << i);
            reg_rd(2'd1, r); reg_rd(2'd1, r2);
            check("R4 set and read", r2, exp_sts());
            reg_wr(2'd1, 32'h0);
            reg_rd(2'd1, r); check("R4 write 0 keeps", r, exp_sts());
            do_w1c(17'h1 << i);
            reg_rd(2'd1, r); check("R4 write 1 clears", r, exp_sts());
        end

        // R5: event and clear in the same cycle, per bit
        for (int i = 0; i < 17; i++) begin
            pulse_evt(17'h1 << i);
            @(negedge clk);
            evt_set = 17'h1 << i; wr_en = 1'b1; reg_sel = 2'd1; wr_data = 32'h1 << i;
            @(negedge clk);
            evt_set = '0; wr_en = 1'b0;
            reg_rd(2'd1, r); check("R5 event wins", r, exp_sts());
            do_w1c(17'h1 << i);
            reg_rd(2'd1, r); check("R5 cleared after", r, exp_sts());
        end

        // R6: interrupt timing and masking per bit
        for (int i = 0; i < 17; i++) begin
            int other;
            other = (i + 1) % 17;
            m_en = 17'h1 << other;
            reg_wr(2'd2, {15'h0, m_en});
            reg_rd(2'd2, r); check("R6 enable readback", r, {15'h0, m_en});
            pulse_evt(17'h1 << i);
            @(negedge clk);
            check("R6 masked stays low", {31'h0, irq}, 32'h0);
            m_en = 17'h1 << i;
            reg_wr(2'd2, {15'h0, m_en});
            check("R6 not yet high", {31'h0, irq}, 32'h0);
            @(negedge clk);
            check("R6 high one cycle later", {31'h0, irq}, 32'h1);
            do_w1c(17'h1 << i);
            check("R6 still high after clear", {31'h0, irq}, 32'h1);
            @(negedge clk);
            check("R6 low after clear", {31'h0, irq}, 32'h0);
        end
        m_en = '0;
        reg_wr(2'd2, 32'h0);

        // R7: error code capture for every code
        for (int c = 0; c < 8; c++) begin
            @(negedge clk);
            bus_err = 1'b1; bus_err_src = c[2:0];
            @(negedge clk);
            bus_err = 1'b0; bus_err_src = ~c[2:0];
            m_err = c[2:0]; m_pend[13] = 1'b1;
            reg_rd(2'd1, r); check("R7 capture", r, exp_sts());
            @(negedge clk);
            check("R7 no irq when disabled", {31'h0, irq}, 32'h0);
            do_w1c(17'h1 << 13);
            reg_rd(2'd1, r); check("R7 code sticky", r, exp_sts());
        end
        m_en = 17'h1 << 13;
        reg_wr(2'd2, {15'h0, m_en});
        @(negedge clk); bus_err = 1'b1; bus_err_src = 3'd5;
        @(negedge clk); bus_err = 1'b0; m_err = 3'd5; m_pend[13] = 1'b1;
        @(negedge clk);
        check("R7 irq via bit 13", {31'h0, irq}, 32'h1);
        do_w1c(17'h1 << 13);
        m_en = '0;
        reg_wr(2'd2, 32'h0);

        // R8: mirror levels, writes have no effect
        for (int m = 0; m < 8; m++) begin
            ts_irq = m[2]; pm_irq = m[1]; cnt_irq = m[0];
            reg_wr(2'd1, 32'hFFFF_FFFF);
            m_pend = '0;
            reg_rd(2'd1, r);
            check("R8 mirrors", {29'h0, r[29:27]}, {29'h0, m[2:0]});
        end
        ts_irq = 1'b0; pm_irq = 1'b0; cnt_irq = 1'b0;

        // R9: tx state field and reserved bits
        for (int s = 0; s < 8; s++) begin
            tx_state = s[2:0];
            pulse_evt(17'h1FFFF);
            reg_rd(2'd1, r); check("R9 status word", r, exp_sts());
            check("R9 reserved zero", r & 32'hC402_0000 | (r & 32'h000E_0000), 32'h0);
            do_w1c(17'h1FFFF);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule